// File: doc/BRIEF.md
# Programmable Interval Counter Channel

One 16-bit down-counting timer channel. Software programs it with a control byte that picks how data bytes are transferred and which counting mode is active. It then loads a reload value one byte at a time through the data port. The channel counts only in clock cycles where the tick enable is high. It drives a single output level whose shape depends on the mode: a terminal-count level, a one-shot level, a periodic one-tick pulse, a square wave or a one-tick strobe.

Reads go through the same byte-wide port. A read returns the live count, or a frozen copy captured by a count-latch pulse. A status-latch pulse captures a status byte, which the next read returns ahead of any count byte. A rising edge on the gate input restarts counting in the retriggerable modes.

The block holds three small state machines:
- Write sequencer: `WS_LOW` and `WS_HIGH`. In the two-byte access mode, the first data write moves it from `WS_LOW` to `WS_HIGH`. The second write loads the count and moves it back to `WS_LOW`. A control write forces `WS_LOW`.
- Read sequencer: `RS_LOW` and `RS_HIGH`. It alternates on each two-byte-mode read. A count latch or a control write returns it to `RS_LOW`.
- Count machine: `CS_IDLE`, `CS_RUN`, `CS_TERM` and `CS_DONE`.
  - A load or a qualifying gate edge moves it from any state to `CS_RUN`.
  - In the single-run modes, the tick that takes the count from 1 to 0 moves it from `CS_RUN` to `CS_TERM`.
  - The next tick moves it from `CS_TERM` to `CS_DONE`.
  - A control write moves it from any state to `CS_IDLE`.

Top module: `ivt_channel`

## Requirements
- R1: The control byte holds three fields.
  - Bits [5:4] select access: 01 is low byte only, 10 is high byte only, 11 is low byte then high byte. With 00, data writes are ignored and count reads return 0.
  - Bits [3:1] select the mode: 000 terminal count, 001 one-shot, 010 rate generator, 011 square wave, 100 software strobe, 101 hardware strobe. The codes 110 and 111 act as 010 and 011.
  - Bit 0 is only reported in the status byte.
- R2: A control write does all of the following:
  - stops counting;
  - makes the count read 0 and drives the output low;
  - marks the count as not loaded;
  - drops any held count latch;
  - returns both byte sequencers to the low byte.
  The same holds after reset.
- R3: Loading depends on the access mode.
  - Low-only access loads {00, byte}. High-only access loads {byte, 00}. Each of these starts counting on that one write.
  - Two-byte access loads only on the second (high) write, and counting starts then.
  - A loaded value of 0 means 65536.
- R4: In mode 0, the output is low while counting and goes high once N ticks have passed. The count then reads 0 and stays there without reloading, and the output stays high.
- R5: In mode 1, the output is high while counting and goes low once N ticks have passed.
- R6: In modes 4 and 5, the output is low while counting. It is high only between the tick that reaches 0 and the next tick, and then stays low.
- R7: In mode 2, the count runs N down to 1. On the tick that would reach 0, it reloads N instead. The output is high from that tick until the next tick.
- R8: In mode 3, each tick lowers the count by 2, and a count of 1 or 2 wraps to count-2+N. The read value after t ticks is N-((2t) mod N). The output is high for the first (N+1)/2 ticks of each N-tick period (N of at least 2).
- R9: Which byte a read returns depends on the access mode.
  - Low-only reads return count[7:0].
  - High-only reads return count[15:8].
  - Two-byte reads alternate, low byte first.
- R10: A count-latch pulse freezes the current count for reading and returns the read sequencer to the low byte. A further count latch while a value is held is ignored. The hold is released by the read of the last byte of the access mode.
- R11: A status-latch pulse captures a status byte:
  - bits [5:0] are control bits [5:0];
  - bit 6 is 1 when no count has been loaded since the last control write;
  - bit 7 is the current output level.
  The next data read returns this byte once, ahead of any count byte, and does not advance the read sequencer.
- R12: A rising gate edge after a load restarts counting from the reload value in modes 1, 2, 3 and 5. In modes 0 and 4, a gate edge has no effect.
- R13: The count changes only in cycles with the tick enable high. A tick in the same cycle as the write that completes a load is not counted.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| ctl_we | input | 1 | Control byte write strobe |
| dat_we | input | 1 | Data byte write strobe |
| wdata | input | 8 | Write byte for control or data |
| dat_re | input | 1 | Data read strobe; consumes the byte shown on rdata |
| rdata | output | 8 | Read byte: status, latched count or live count |
| latch_cnt | input | 1 | Count-latch pulse |
| latch_sts | input | 1 | Status-latch pulse |
| gate | input | 1 | Gate; a rising edge restarts the retriggerable modes |
| tick_en | input | 1 | Count enable, one tick per enabled cycle |
| out | output | 1 | Channel output level |

## Verification
The bench targets the following corners:
- **Two-byte load start.** A channel that started counting after the first byte would show a cleared not-loaded bit too early and reach terminal count early.
- **Count 0 as 65536.** A design that treated 0 literally would read 0 instead of 0xFFFF after one tick.
- **Repeated count latch.** A design that accepted the repeat would return the later, smaller count.
- **Status priority.** A design that let status take no priority, or return more than once, would put a count byte where the status byte belongs.
- **Gate edges.** These must restart the rate generator and the one-shot but leave modes 0 and 4 alone.
- **Periodic modes.** Random reload values and tick counts in modes 0 to 4 are compared against closed-form count and output functions. An off-by-one in the wrap points of mode 2 or mode 3 shows up there.

// File: rtl/ivt_pkg.sv
package ivt_pkg;

    typedef enum logic [1:0] {
        ACC_NONE = 2'b00,
        ACC_LO   = 2'b01,
        ACC_HI   = 2'b10,
        ACC_BOTH = 2'b11
    } acc_e;

    typedef enum logic [2:0] {
        MD_TERM    = 3'd0,
        MD_ONESHOT = 3'd1,
        MD_RATE    = 3'd2,
        MD_SQUARE  = 3'd3,
        MD_SWSTB   = 3'd4,
        MD_HWSTB   = 3'd5
    } mode_e;

    typedef enum logic [1:0] {
        CS_IDLE,
        CS_RUN,
        CS_TERM,
        CS_DONE
    } cnt_st_e;

    typedef enum logic { WS_LOW, WS_HIGH } wr_st_e;
    typedef enum logic { RS_LOW, RS_HIGH } rd_st_e;

    // Codes 110 and 111 fold onto the rate generator and square wave.
    function automatic mode_e decode_mode(input logic [2:0] m);
        if (m[1]) return mode_e'({1'b0, m[1:0]});
        return mode_e'(m);
    endfunction

endpackage

// File: rtl/ivt_ctrl.sv
module ivt_ctrl
    import ivt_pkg::*;
#(
    parameter int BYTE_W = 8,
    localparam int CNT_W = 2 * BYTE_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              ctl_we,
    input  logic              dat_we,
    input  logic [BYTE_W-1:0] wdata,
    output logic [5:0]        ctl_bits,
    output acc_e              acc,
    output mode_e             mode,
    output logic              load,
    output logic [CNT_W:0]    ld_val
);

    wr_st_e            ws, ws_n;
    logic [5:0]        ctl_q;
    logic [BYTE_W-1:0] lo_q, lo_n;
    logic [CNT_W-1:0]  raw;

    assign ctl_bits = ctl_q;
    assign acc      = acc_e'(ctl_q[5:4]);
    assign mode     = decode_mode(ctl_q[3:1]);

    // State register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ws    <= WS_LOW;
            ctl_q <= '0;
            lo_q  <= '0;
        end else begin
            ws   <= ws_n;
            lo_q <= lo_n;
            if (ctl_we) ctl_q <= wdata[5:0];
        end
    end

    // Next state and load decode
    always_comb begin
        ws_n = ws;
        lo_n = lo_q;
        load = 1'b0;
        raw  = '0;
        if (ctl_we) begin
            ws_n = WS_LOW;
        end else if (dat_we) begin
            unique case (acc)
                ACC_LO: begin
                    raw  = {{BYTE_W{1'b0}}, wdata};
                    load = 1'b1;
                end
                ACC_HI: begin
                    raw  = {wdata, {BYTE_W{1'b0}}};
                    load = 1'b1;
                end
                ACC_BOTH: begin
                    unique case (ws)
                        WS_LOW: begin
                            lo_n = wdata;
                            ws_n = WS_HIGH;
                        end
                        WS_HIGH: begin
                            raw  = {wdata, lo_q};
                            load = 1'b1;
                            ws_n = WS_LOW;
                        end
                        default: ws_n = WS_LOW;
                    endcase
                end
                default: ;
            endcase
        end
    end

    // A loaded zero stands for the full range.
    assign ld_val = (raw == '0) ? (CNT_W + 1)'(1) << CNT_W : {1'b0, raw};

    p_high_wait_both_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (ws == WS_HIGH) |-> (acc == ACC_BOTH));

    p_ctl_resets_toggle_r2: assert property (@(posedge clk) disable iff (!rst_n)
        ctl_we |=> (ws == WS_LOW));

endmodule

// File: rtl/ivt_core.sv
module ivt_core
    import ivt_pkg::*;
#(
    parameter int CNT_W = 16,
    localparam int NV_W = CNT_W + 1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clear,
    input  logic             load,
    input  logic [CNT_W:0]   ld_val,
    input  mode_e            mode,
    input  logic             tick,
    input  logic             gate,
    output logic             out,
    output logic             armed,
    output logic [CNT_W-1:0] value
);

    cnt_st_e         st, st_n;
    logic [CNT_W:0]  c, c_n, nv, nv_n, ph, ph_n, half;
    logic            pl, pl_n, gate_q, rise, retrig;

    assign rise   = gate & ~gate_q;
    assign retrig = (mode == MD_ONESHOT) || (mode == MD_RATE) ||
                    (mode == MD_SQUARE)  || (mode == MD_HWSTB);
    assign half   = (nv + NV_W'(1)) >> 1;

    // State register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st     <= CS_IDLE;
            c      <= '0;
            nv     <= '0;
            ph     <= '0;
            pl     <= 1'b0;
            gate_q <= 1'b0;
        end else begin
            st     <= st_n;
            c      <= c_n;
            nv     <= nv_n;
            ph     <= ph_n;
            pl     <= pl_n;
            gate_q <= gate;
        end
    end

    // Next state: clear, then load, then gate restart, then tick.
    always_comb begin
        st_n = st;
        c_n  = c;
        nv_n = nv;
        ph_n = ph;
        pl_n = pl;
        if (clear) begin
            st_n = CS_IDLE;
            c_n  = '0;
            ph_n = '0;
            pl_n = 1'b0;
        end else if (load) begin
            st_n = CS_RUN;
            nv_n = ld_val;
            c_n  = ld_val;
            ph_n = '0;
            pl_n = 1'b0;
        end else if (rise && retrig && (st != CS_IDLE)) begin
            st_n = CS_RUN;
            c_n  = nv;
            ph_n = '0;
            pl_n = 1'b0;
        end else if (tick) begin
            unique case (st)
                CS_RUN: begin
                    unique case (mode)
                        MD_RATE: begin
                            pl_n = (c == NV_W'(1));
                            c_n  = (c == NV_W'(1)) ? nv : c - NV_W'(1);
                        end
                        MD_SQUARE: begin
                            c_n  = (c > NV_W'(2)) ? c - NV_W'(2) : c - NV_W'(2) + nv;
                            ph_n = (ph == nv - NV_W'(1)) ? '0 : ph + NV_W'(1);
                        end
                        default: begin
                            c_n = c - NV_W'(1);
                            if (c == NV_W'(1)) st_n = CS_TERM;
                        end
                    endcase
                end
                CS_TERM: st_n = CS_DONE;
                default: ;
            endcase
        end
    end

    // Outputs
    always_comb begin
        out = 1'b0;
        unique case (st)
            CS_RUN: begin
                unique case (mode)
                    MD_ONESHOT: out = 1'b1;
                    MD_RATE:    out = pl;
                    MD_SQUARE:  out = (ph < half);
                    default:    out = 1'b0;
                endcase
            end
            CS_TERM: out = (mode != MD_ONESHOT);
            CS_DONE: out = (mode == MD_TERM);
            default: out = 1'b0;
        endcase
    end

    assign armed = (st != CS_IDLE);
    assign value = c[CNT_W-1:0];

    p_idle_quiet_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (st == CS_IDLE) |-> (value == '0 && !out));

    p_term_holds_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (mode == MD_TERM && out && !clear && !load) |=> out);

    p_pulse_one_tick_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (mode == MD_RATE && pl && tick && c != NV_W'(1) && !clear && !load && !rise) |=> !pl);

    p_no_tick_stable_r13: assert property (@(posedge clk) disable iff (!rst_n)
        (!tick && !clear && !load && !rise) |=> $stable(c));

    p_count_bound_r3: assert property (@(posedge clk) disable iff (!rst_n)
        armed |-> (c <= nv));

endmodule

// File: rtl/ivt_rdpath.sv
module ivt_rdpath
    import ivt_pkg::*;
#(
    parameter int BYTE_W = 8,
    localparam int CNT_W = 2 * BYTE_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              clear,
    input  acc_e              acc,
    input  logic [5:0]        ctl_bits,
    input  logic [CNT_W-1:0]  live,
    input  logic              out_lvl,
    input  logic              armed,
    input  logic              latch_cnt,
    input  logic              latch_sts,
    input  logic              dat_re,
    output logic [BYTE_W-1:0] rdata
);

    rd_st_e            rs, rs_n;
    logic              hold, hold_n, sts_v, sts_v_n;
    logic [CNT_W-1:0]  hv, hv_n, sel;
    logic [BYTE_W-1:0] sts, sts_n;

    // State register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rs    <= RS_LOW;
            hold  <= 1'b0;
            hv    <= '0;
            sts_v <= 1'b0;
            sts   <= '0;
        end else begin
            rs    <= rs_n;
            hold  <= hold_n;
            hv    <= hv_n;
            sts_v <= sts_v_n;
            sts   <= sts_n;
        end
    end

    // Next state: a read is consumed first, then the latch pulses apply.
    always_comb begin
        rs_n    = rs;
        hold_n  = hold;
        hv_n    = hv;
        sts_v_n = sts_v;
        sts_n   = sts;
        if (clear) begin
            rs_n   = RS_LOW;
            hold_n = 1'b0;
        end else begin
            if (dat_re) begin
                if (sts_v) begin
                    sts_v_n = 1'b0;
                end else begin
                    unique case (acc)
                        ACC_LO, ACC_HI: hold_n = 1'b0;
                        ACC_BOTH: begin
                            unique case (rs)
                                RS_LOW:  rs_n = RS_HIGH;
                                RS_HIGH: begin
                                    rs_n   = RS_LOW;
                                    hold_n = 1'b0;
                                end
                                default: rs_n = RS_LOW;
                            endcase
                        end
                        default: ;
                    endcase
                end
            end
            if (latch_cnt && !hold) begin
                hv_n   = live;
                hold_n = 1'b1;
                rs_n   = RS_LOW;
            end
            if (latch_sts) begin
                sts_n   = BYTE_W'({out_lvl, ~armed, ctl_bits});
                sts_v_n = 1'b1;
            end
        end
    end

    // Output byte select
    always_comb begin
        sel = hold ? hv : live;
        if (sts_v) begin
            rdata = sts;
        end else begin
            unique case (acc)
                ACC_LO:   rdata = sel[BYTE_W-1:0];
                ACC_HI:   rdata = sel[CNT_W-1:BYTE_W];
                ACC_BOTH: rdata = (rs == RS_LOW) ? sel[BYTE_W-1:0] : sel[CNT_W-1:BYTE_W];
                default:  rdata = '0;
            endcase
        end
    end

    p_latch_ignored_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (hold && latch_cnt && !dat_re && !clear) |=> (hold && $stable(hv)));

    p_status_once_r11: assert property (@(posedge clk) disable iff (!rst_n)
        (sts_v && dat_re && !latch_sts && !clear) |=> !sts_v);

    p_status_keeps_toggle_r11: assert property (@(posedge clk) disable iff (!rst_n)
        (sts_v && dat_re && !latch_cnt && !clear) |=> $stable(rs));

endmodule

// File: rtl/ivt_channel.sv
module ivt_channel
    import ivt_pkg::*;
#(
    parameter int BYTE_W = 8,
    localparam int CNT_W = 2 * BYTE_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              ctl_we,
    input  logic              dat_we,
    input  logic [BYTE_W-1:0] wdata,
    input  logic              dat_re,
    output logic [BYTE_W-1:0] rdata,
    input  logic              latch_cnt,
    input  logic              latch_sts,
    input  logic              gate,
    input  logic              tick_en,
    output logic              out
);

    logic [5:0]       ctl_bits;
    acc_e             acc;
    mode_e            mode;
    logic             load, armed;
    logic [CNT_W:0]   ld_val;
    logic [CNT_W-1:0] value;

    ivt_ctrl #(.BYTE_W(BYTE_W)) u_ctrl (
        .clk      (clk),
        .rst_n    (rst_n),
        .ctl_we   (ctl_we),
        .dat_we   (dat_we),
        .wdata    (wdata),
        .ctl_bits (ctl_bits),
        .acc      (acc),
        .mode     (mode),
        .load     (load),
        .ld_val   (ld_val)
    );

    ivt_core #(.CNT_W(CNT_W)) u_core (
        .clk    (clk),
        .rst_n  (rst_n),
        .clear  (ctl_we),
        .load   (load),
        .ld_val (ld_val),
        .mode   (mode),
        .tick   (tick_en),
        .gate   (gate),
        .out    (out),
        .armed  (armed),
        .value  (value)
    );

    ivt_rdpath #(.BYTE_W(BYTE_W)) u_rd (
        .clk       (clk),
        .rst_n     (rst_n),
        .clear     (ctl_we),
        .acc       (acc),
        .ctl_bits  (ctl_bits),
        .live      (value),
        .out_lvl   (out),
        .armed     (armed),
        .latch_cnt (latch_cnt),
        .latch_sts (latch_sts),
        .dat_re    (dat_re),
        .rdata     (rdata)
    );

endmodule

// File: tb/ivt_channel_tb.sv
module ivt_channel_tb;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       ctl_we = 1'b0, dat_we = 1'b0, dat_re = 1'b0;
    logic [7:0] wdata = '0;
    logic [7:0] rdata;
    logic       latch_cnt = 1'b0, latch_sts = 1'b0, gate = 1'b0, tick_en = 1'b0;
    logic       out;

    int n_chk = 0;
    int n_bad = 0;
    int cyc = 0;
    bit done = 1'b0;

    always #4 clk = ~clk;

    ivt_channel u_dut (
        .clk(clk), .rst_n(rst_n), .ctl_we(ctl_we), .dat_we(dat_we), .wdata(wdata),
        .dat_re(dat_re), .rdata(rdata), .latch_cnt(latch_cnt), .latch_sts(latch_sts),
        .gate(gate), .tick_en(tick_en), .out(out)
    );

    task automatic finish_run();
        if (!done) begin
            done = 1'b1;
            $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    endtask

    always @(posedge clk) begin
        cyc <= cyc + 1;
        if (cyc == 150000) begin
            n_bad = n_bad + 1;
            $display("FAIL watchdog: actual=hung expected=finished");
            finish_run();
        end
    end

    task automatic chk(input string req, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic wr_ctl(input logic [7:0] b);
        @(negedge clk); ctl_we = 1'b1; wdata = b;
        @(negedge clk); ctl_we = 1'b0;
    endtask

    task automatic wr_dat(input logic [7:0] b);
        @(negedge clk); dat_we = 1'b1; wdata = b;
        @(negedge clk); dat_we = 1'b0;
    endtask

    task automatic rd(output logic [7:0] v);
        @(negedge clk); dat_re = 1'b1; #1 v = rdata;
        @(negedge clk); dat_re = 1'b0;
    endtask

    task automatic rd16(output int v);
        logic [7:0] lo, hi;
        rd(lo); rd(hi);
        v = {hi, lo};
    endtask

    task automatic ticks(input int n);
        for (int i = 0; i < n; i++) begin
            @(negedge clk); tick_en = 1'b1;
        end
        @(negedge clk); tick_en = 1'b0;
    endtask

    task automatic lat_c();
        @(negedge clk); latch_cnt = 1'b1;
        @(negedge clk); latch_cnt = 1'b0;
    endtask

    task automatic lat_s();
        @(negedge clk); latch_sts = 1'b1;
        @(negedge clk); latch_sts = 1'b0;
    endtask

    task automatic pulse_gate();
        @(negedge clk); gate = 1'b1;
        @(negedge clk); gate = 1'b0;
    endtask

    task automatic load16(input int n);
        wr_dat(8'(n)); wr_dat(8'(n >> 8));
    endtask

    function automatic int exp_val(int md, int n, int t);
        case (md)
            2: return n - (t % n);
            3: return n - ((2 * t) % n);
            default: return (t >= n) ? 0 : n - t;
        endcase
    endfunction

    function automatic int exp_out(int md, int n, int t);
        case (md)
            0: return int'(t >= n);
            1: return int'(t < n);
            2: return int'(t != 0 && (t % n) == 0);
            3: return int'((t % n) < (n + 1) / 2);
            default: return int'(t == n);
        endcase
    endfunction

    initial begin
        logic [7:0] b;
        int v;
        int seed;
        seed = int'($urandom(32'd20240611));
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // Reset state (R2)
        chk("R2 reset out", int'(out), 0);
        chk("R2 reset rdata", int'(rdata), 0);

        // Access 00 ignores data (R1)
        wr_ctl(8'h00); wr_dat(8'h55); lat_s(); rd(b);
        chk("R1 access-none write ignored, status", int'(b), 8'h40);

        // Low-only load and read (R3, R9, R4)
        wr_ctl(8'h10); wr_dat(8'h34); lat_c(); rd(b);
        chk("R9 low-only read", int'(b), 8'h34);
        ticks(8'h33); chk("R3 low-only load not yet terminal", int'(out), 0);
        ticks(1);     chk("R4 low-only terminal after N", int'(out), 1);

        // High-only load (R3, R9)
        wr_ctl(8'h20); wr_dat(8'h01); lat_c(); rd(b);
        chk("R9 high-only read", int'(b), 8'h01);
        ticks(255); chk("R3 high-only low byte zero, before", int'(out), 0);
        ticks(1);   chk("R3 high-only low byte zero, at N", int'(out), 1);

        // Zero means 65536 (R3)
        wr_ctl(8'h30); load16(0); ticks(1); lat_c(); rd16(v);
        chk("R3 zero load is 65536", v, 16'hFFFF);

        // Two-byte start and mode 0 (R3, R11, R4)
        wr_ctl(8'h30); wr_dat(8'h05); ticks(3); lat_s(); rd(b);
        chk("R11 not loaded after first byte", int'(b), 8'h70);
        wr_dat(8'h00); lat_s(); rd(b);
        chk("R11 loaded after high byte", int'(b), 8'h30);
        ticks(4); chk("R4 low while counting", int'(out), 0);
        rd16(v);  chk("R9 live low-then-high read", v, 1);
        ticks(1); chk("R4 high at terminal", int'(out), 1);
        ticks(3); lat_c(); rd16(v);
        chk("R4 stays at zero", v, 0);
        chk("R4 stays high", int'(out), 1);

        // Count latch (R10)
        wr_ctl(8'h34); load16(1000); ticks(10); lat_c(); ticks(5); lat_c(); rd16(v);
        chk("R10 repeat latch ignored", v, 990);
        lat_c(); rd16(v);
        chk("R10 latch after release", v, 985);

        // Status priority and square wave (R11, R8)
        wr_ctl(8'h36); lat_s(); rd(b);
        chk("R11 status before load", int'(b), 8'h76);
        rd(b);
        chk("R11 status only once", int'(b), 0);
        wr_ctl(8'h36); load16(10); lat_s(); rd(b);
        chk("R11 status shows output", int'(b), 8'hB6);
        ticks(3); lat_c(); rd16(v);
        chk("R8 steps by two", v, 4);
        chk("R8 high in first half", int'(out), 1);
        ticks(2); chk("R8 low in second half", int'(out), 0);

        // Folded mode code and rate pulse (R1, R7)
        wr_ctl(8'h3C); load16(4); ticks(4);
        chk("R1 code 110 acts as rate generator", int'(out), 1);
        ticks(1); chk("R7 pulse lasts one tick", int'(out), 0);

        // Strobe (R6)
        wr_ctl(8'h38); load16(3); ticks(2);
        chk("R6 low before zero", int'(out), 0);
        ticks(1); chk("R6 strobe at zero", int'(out), 1);
        ticks(1); chk("R6 strobe ends", int'(out), 0);
        ticks(5); chk("R6 stays low", int'(out), 0);

        // Gate (R12, R5)
        wr_ctl(8'h34); load16(100); ticks(30); pulse_gate(); ticks(5); lat_c(); rd16(v);
        chk("R12 gate restarts rate generator", v, 95);
        wr_ctl(8'h30); load16(100); ticks(30); pulse_gate(); ticks(5); lat_c(); rd16(v);
        chk("R12 gate ignored in mode 0", v, 65);
        wr_ctl(8'h38); load16(100); ticks(30); pulse_gate(); ticks(5); lat_c(); rd16(v);
        chk("R12 gate ignored in mode 4", v, 65);
        wr_ctl(8'h32); load16(100);
        chk("R5 one-shot high while counting", int'(out), 1);
        ticks(100); chk("R5 one-shot low after N", int'(out), 0);
        pulse_gate(); chk("R12 gate retriggers one-shot", int'(out), 1);

        // Load wins over a same-cycle tick (R13)
        wr_ctl(8'h10);
        @(negedge clk); dat_we = 1'b1; wdata = 8'h05; tick_en = 1'b1;
        @(negedge clk); dat_we = 1'b0; tick_en = 1'b0;
        ticks(4); chk("R13 tick with load not counted", int'(out), 0);
        ticks(1); chk("R13 terminal after N ticks", int'(out), 1);

        // Control write mid count (R2)
        wr_ctl(8'h34); load16(50); ticks(7); lat_c(); wr_ctl(8'h34); rd16(v);
        chk("R2 control write drops latch, count 0", v, 0);
        chk("R2 control write drives output low", int'(out), 0);
        lat_s(); rd(b);
        chk("R2 control write marks not loaded", int'(b), 8'h74);

        // Random modes against closed-form functions
        for (int it = 0; it < 40; it++) begin
            int md, n, t;
            string tag;
            md = int'($urandom_range(4, 0));
            n  = int'($urandom_range(400, 2));
            t  = int'($urandom_range(900, 0));
            tag = (md == 0) ? "R4" : (md == 1) ? "R5" : (md == 2) ? "R7" : (md == 3) ? "R8" : "R6";
            wr_ctl(8'(8'h30 | (md << 1)));
            load16(n);
            ticks(t);
            chk({tag, " random output"}, int'(out), exp_out(md, n, t));
            lat_c(); rd16(v);
            chk({tag, " random count"}, v, exp_val(md, n, t));
        end

        finish_run();
    end

endmodule